// File: doc/BRIEF.md
# Bus-Stalling UART Transmitter

This block is a transmit-only serial port that hangs off a simple 32-bit processor memory bus with a valid/ready handshake. It has a single register, the transmit data register at byte address 0x03000100. A store to that address takes the low byte of the write data, sends it as one asynchronous serial character, and does not complete until the stop bit has finished. Software can print a string with a loop of plain stores. The store itself throttles the loop to the line rate, so no status polling or overrun handling is needed.

The same ready output can be wired to an interrupt input of the processor instead of to the bus. It then gives one pulse per finished character, and software can keep its own queue of characters and feed the next one from the interrupt handler. A request that is present while a character is being sent, or during the completion pulse, is held off. Its byte is captured only once the block is idle again.

Top module: `stall_uart_tx`

## Requirements
- R1: Out of reset, and whenever no character is being sent, `txd` is high and `mem_ready` is low.
- R2: A character is sent as ten bit cells of exactly CLKS_PER_BIT clocks each: a low start cell, then the eight data bits least significant first, then a high stop cell.
- R3: A request is a write when any bit of `mem_wstrb` is set. Only `mem_wdata[7:0]` is sent, whatever the upper data bits and whichever strobes are set.
- R4: A write is accepted on the clock edge where a write request to the register meets an idle block, and `txd` goes low at that edge. `mem_ready` stays low for the next 10*CLKS_PER_BIT cycles and is high in cycle 10*CLKS_PER_BIT after acceptance, which is after the stop cell.
- R5: The byte is captured at acceptance. Changes on `mem_wdata` during the character do not alter the bits sent.
- R6: A write request still present during the ready cycle is not accepted at the edge that ends that cycle. It is accepted at the following edge, so its start cell begins two edges after the ready cycle begins.
- R7: Requests whose address differs from BASE_ADDR in any bit get no `mem_ready` and cause no activity on `txd`.
- R8: A read (all strobes zero) of the register, made while idle, is answered with `mem_ready` high in the next cycle and `mem_rdata` equal to zero, and starts no transmission.
- R9: `mem_ready` is a single-cycle pulse and is never high on two consecutive cycles, so it can serve as an edge-free interrupt request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_valid | input | 1 | Bus request present |
| mem_addr | input | ADDR_W | Byte address of the request |
| mem_wdata | input | DATA_W | Write data; bits 7:0 form the character |
| mem_wstrb | input | DATA_W/8 | Byte strobes; any set bit marks a write |
| mem_ready | output | 1 | Request complete; also usable as end-of-character interrupt |
| mem_rdata | output | DATA_W | Read data, always zero |
| txd | output | 1 | Serial line, idles high |

## Verification
The bench goes after the edges of the ready pulse. If ready came one cycle early, software would overwrite a character still on the line. If it came one cycle late, or stayed high for two cycles, a master that keeps its request up would have its byte sent twice. A held request that changes its data mid-character shows whether the byte is captured at acceptance: a design that shifted straight from the bus would send a mix of the two bytes. Bytes with random upper bits and random strobe patterns, reads, and near-miss addresses show whether the decode ignores what it should. A wrong decode would start frames on stray stores or hang a read.

// File: rtl/stall_uart_tx_pkg.sv
package stall_uart_tx_pkg;

    localparam int CHAR_BITS = 8;
    localparam int CELLS_PER_CHAR = CHAR_BITS + 2;
    localparam int LEFT_W = $clog2(CELLS_PER_CHAR);

    typedef enum logic [1:0] {
        CTL_IDLE = 2'd0,
        CTL_XMIT = 2'd1,
        CTL_ACK  = 2'd2
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e state;
    } ctl_regs_t;

    typedef struct packed {
        logic                   busy;
        logic                   line;
        logic [CHAR_BITS:0]     shreg;   // remaining data bits plus stop bit
        logic [LEFT_W-1:0]      left;    // cells still to follow the current one
    } frm_regs_t;

endpackage

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
    parameter int CLKS_PER_BIT = 868,
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic cell_end
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        cell_end = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
            cnt_d    = '0;
            cell_end = 1'b1;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/utx_framer.sv
module utx_framer
    import stall_uart_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [CHAR_BITS-1:0] char_in,
    input  logic                 cell_end,
    output logic                 busy,
    output logic                 line,
    output logic                 frame_end
);

    frm_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        frame_end = 1'b0;
        if (load && !r_q.busy) begin
            r_d.busy  = 1'b1;
            r_d.line  = 1'b0;                       // start cell
            r_d.shreg = {1'b1, char_in};            // stop bit above the data
            r_d.left  = LEFT_W'(CELLS_PER_CHAR - 1);
        end else if (r_q.busy && cell_end) begin
            if (r_q.left == '0) begin
                r_d.busy  = 1'b0;
                r_d.line  = 1'b1;
                frame_end = 1'b1;
            end else begin
                r_d.line  = r_q.shreg[0];
                r_d.shreg = {1'b1, r_q.shreg[CHAR_BITS:1]};
                r_d.left  = r_q.left - LEFT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.busy  <= 1'b0;
            r_q.line  <= 1'b1;
            r_q.shreg <= '1;
            r_q.left  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = r_q.busy;
    assign line = r_q.line;

endmodule

// File: rtl/utx_bus_port.sv
module utx_bus_port
    import stall_uart_tx_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          STRB_W    = 4,
    parameter logic [31:0] BASE_ADDR = 32'h0300_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [STRB_W-1:0] req_wstrb,
    input  logic              frame_end,
    output logic              load,
    output logic              ready
);

    ctl_regs_t r_d, r_q;
    logic      hit;
    logic      is_write;

    assign hit      = req_valid && (req_addr == ADDR_W'(BASE_ADDR));
    assign is_write = |req_wstrb;

    always_comb begin
        r_d  = r_q;
        load = 1'b0;
        unique case (r_q.state)
            CTL_IDLE: begin
                if (hit && is_write) begin
                    load      = 1'b1;
                    r_d.state = CTL_XMIT;
                end else if (hit) begin
                    r_d.state = CTL_ACK;
                end
            end
            CTL_XMIT: begin
                if (frame_end) r_d.state = CTL_ACK;
            end
            CTL_ACK: begin
                r_d.state = CTL_IDLE;
            end
            default: r_d.state = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q.state <= CTL_IDLE;
        else        r_q       <= r_d;
    end

    assign ready = (r_q.state == CTL_ACK);

endmodule

// File: rtl/stall_uart_tx.sv
module stall_uart_tx
    import stall_uart_tx_pkg::*;
#(
    parameter int          CLKS_PER_BIT = 868,
    parameter int          ADDR_W       = 32,
    parameter int          DATA_W       = 32,
    parameter logic [31:0] BASE_ADDR    = 32'h0300_0100,
    localparam int         STRB_W       = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    input  logic [STRB_W-1:0] mem_wstrb,
    output logic              mem_ready,
    output logic [DATA_W-1:0] mem_rdata,
    output logic              txd
);

    logic frm_load;
    logic frm_busy;
    logic frm_end;
    logic cell_end;
    logic unused_upper;

    assign unused_upper = ^mem_wdata[DATA_W-1:CHAR_BITS];

    utx_bus_port #(
        .ADDR_W   (ADDR_W),
        .STRB_W   (STRB_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(mem_valid),
        .req_addr (mem_addr),
        .req_wstrb(mem_wstrb),
        .frame_end(frm_end),
        .load     (frm_load),
        .ready    (mem_ready)
    );

    utx_bit_timer #(
        .CLKS_PER_BIT(CLKS_PER_BIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (frm_busy),
        .cell_end(cell_end)
    );

    utx_framer u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frm_load),
        .char_in  (mem_wdata[CHAR_BITS-1:0]),
        .cell_end (cell_end),
        .busy     (frm_busy),
        .line     (txd),
        .frame_end(frm_end)
    );

    assign mem_rdata = '0;

endmodule

module stall_uart_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_ready,
    input logic txd,
    input logic frm_busy
);

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |=> !mem_ready);

    // R4
    no_ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_busy |-> !mem_ready);

    // R4
    ready_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frm_busy) |-> (mem_ready && txd));

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_busy |-> txd);

    // R2
    start_cell_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_busy) |-> !txd);

endmodule

bind stall_uart_tx stall_uart_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_ready(mem_ready),
    .txd      (txd),
    .frm_busy (frm_busy)
);

// File: tb/test_stall_uart_tx.sv
module test_stall_uart_tx;

    localparam int          CPB   = 8;
    localparam int          FRAME = 10 * CPB;
    localparam logic [31:0] BASE  = 32'h0300_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_addr = '0;
    logic [31:0] mem_wdata = '0;
    logic [3:0]  mem_wstrb = '0;
    logic        mem_ready;
    logic [31:0] mem_rdata;
    logic        txd;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    stall_uart_tx #(
        .CLKS_PER_BIT(CPB),
        .BASE_ADDR   (BASE)
    ) i_stall_uart_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_valid(mem_valid),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_wstrb(mem_wstrb),
        .mem_ready(mem_ready),
        .mem_rdata(mem_rdata),
        .txd      (txd)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected line level in cell k of a character
    function automatic logic cell_level(input logic [7:0] b, input int k);
        if (k == 0) return 1'b0;
        if (k >= 9) return 1'b1;
        return b[k-1];
    endfunction

    // Called at a negedge; returns at a negedge.
    task automatic send(input logic [31:0] wd, input logic [3:0] st, input bit keep,
                        input bit swap, input logic [31:0] swap_wd, input string tag);
        logic [7:0] exp_b;
        logic [7:0] got;
        int ready_err;
        int line_err;
        int k;
        exp_b = wd[7:0];
        got = '0;
        ready_err = 0;
        line_err = 0;
        mem_valid = 1'b1;
        mem_addr  = BASE;
        mem_wdata = wd;
        mem_wstrb = st;
        @(posedge clk);
        for (int c = 0; c <= FRAME + 1; c++) begin
            @(negedge clk);
            if (mem_ready !== (c == FRAME)) ready_err++;
            if (c < FRAME) begin
                if (c % CPB == CPB / 2) begin
                    k = c / CPB;
                    if (k >= 1 && k <= 8) got[k-1] = txd;
                    else if (txd !== cell_level(exp_b, k)) line_err++;
                end
            end else if (txd !== 1'b1) begin
                line_err++;
            end
            if (swap && c == 3 * CPB) mem_wdata = swap_wd;
            if (c == FRAME && !keep) begin
                mem_valid = 1'b0;
                mem_wstrb = '0;
            end
            if (c < FRAME + 1) @(posedge clk);
        end
        check(got == exp_b, {tag, " data bits sent"}, {24'h0, got}, {24'h0, exp_b});
        check(line_err == 0, "R2 start/stop cells", line_err, 0);
        check(ready_err == 0, "R4 ready timing", ready_err, 0);
    endtask

    task automatic read_reg();
        mem_valid = 1'b1;
        mem_addr  = BASE;
        mem_wstrb = 4'h0;
        mem_wdata = $urandom;
        @(posedge clk);
        @(negedge clk);
        check(mem_ready === 1'b1, "R8 read ready", {31'h0, mem_ready}, 1);
        check(mem_rdata === 32'h0, "R8 read data", mem_rdata, 0);
        mem_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(mem_ready === 1'b0 && txd === 1'b1, "R8 no transmission after read",
              {30'h0, mem_ready, txd}, 32'h1);
    endtask

    task automatic bad_addr(input logic [31:0] a);
        int err;
        err = 0;
        mem_valid = 1'b1;
        mem_addr  = a;
        mem_wstrb = 4'hF;
        mem_wdata = 32'h0000_0000;
        for (int i = 0; i < 30; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (mem_ready !== 1'b0 || txd !== 1'b1) err++;
        end
        mem_valid = 1'b0;
        mem_wstrb = '0;
        check(err == 0, "R7 foreign address ignored", err, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        logic [31:0] wd;
        logic [3:0]  st;
        void'($urandom(32'd20240));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(txd === 1'b1 && mem_ready === 1'b0, "R1 state in reset", {30'h0, txd, mem_ready}, 32'h2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(txd === 1'b1 && mem_ready === 1'b0, "R1 idle after reset", {30'h0, txd, mem_ready}, 32'h2);

        send(32'h0000_0055, 4'hF, 1'b0, 1'b0, '0, "R2");
        send(32'h0000_0000, 4'hF, 1'b0, 1'b0, '0, "R2");
        send(32'h0000_00FF, 4'hF, 1'b0, 1'b0, '0, "R2");
        send(32'hDEAD_BEA3, 4'b0001, 1'b0, 1'b0, '0, "R3");
        send(32'h1234_5601, 4'b1000, 1'b0, 1'b0, '0, "R3");

        // R5 then R6: request stays up through the ready cycle with new data
        send(32'h0000_0081, 4'hF, 1'b1, 1'b1, 32'h0000_003C, "R5");
        send(32'h0000_003C, 4'hF, 1'b0, 1'b0, '0, "R6");

        read_reg();
        bad_addr(BASE + 32'd4);
        bad_addr(BASE ^ 32'h0100_0000);
        @(negedge clk);

        for (int n = 0; n < 20; n++) begin
            wd = $urandom;
            st = 4'($urandom_range(1, 15));
            send(wd, st, 1'b0, 1'b0, '0, "R3");
        end

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R4 actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule